// File: doc/BRIEF.md
# Four-Queue Circular Pointer Manager

This block keeps the head and tail pointers of four circular word queues that live back to back in one shared memory region. The queues, by index, are: 0 inbound free, 1 inbound post, 2 outbound post and 3 outbound free. They are laid out in that order from the region base, and each has the same span. The span is the size code times one size unit (16 KB at the default `UNIT_LG2` of 14). The memory sits outside the block. The block only produces the word address, the write data and the strobes for it, and returns the read word to the requester.

A hardware requester pushes into queues 1 and 3 and pops from queues 0 and 2. A processor-side register port moves the other pointer of each queue by writing it directly. It can also move any pointer this way. The same port sets the enable bit and the size code, programs the base address, and reads and clears two status bits. Each pointer is a byte offset from the region base. It steps by one word and wraps to the start of its own queue. Empty and full are worked out from the head and tail.

Top module: `qptr_mgr`

## Requirements
- R1: After reset, the control, base, pointer and status registers read zero, all four `q_empty` bits are 1, `irq_post` is 0 and neither memory strobe is active.
- R2: Register index map on `sw_addr`: 0 is control, 1 is base, 2+2q is the head of queue q, 3+2q is its tail, and 10 is status. Any other index reads zero. Control bit 0 is the enable and bits SIZE_W:1 are the size code. The base register keeps only bits ADDR_W-1:BASE_LSB, so the region is 2^BASE_LSB aligned. Status bit 0 is the post flag and bit 1 is the overflow flag.
- R3: A control write with bit 0 set sets the head and tail of every queue q to q × (size code × 2^UNIT_LG2), using the newly written size code. This overrides any other pointer update in that cycle.
- R4: An accepted hardware push (enabled, queue 1 or 3, not full) raises `mem_we` in the same cycle. It drives `mem_addr` = region base + head and `mem_wdata` = `hw_wdata`, and the head advances at the next edge.
- R5: An accepted hardware pop (enabled, queue 0 or 2, not empty) raises `mem_re` in the same cycle. It drives `mem_addr` = region base + tail and `hw_rdata` = `mem_rdata`, and the tail advances at the next edge.
- R6: A pointer advance adds 4. It returns the pointer to its queue start instead when the result would reach start + span, or when the pointer lies below its queue start.
- R7: A queue is empty when head equals tail. It is full when the advanced head equals the tail.
- R8: A hardware push into a full queue is dropped. There is no `mem_we`, the head is unchanged, and the sticky overflow flag is set. The flag stays set until it is cleared.
- R9: A hardware pop from an empty queue returns all ones on `hw_rdata`, raises no `mem_re` and moves no pointer.
- R10: An accepted push into queue 1 sets the post flag, and `irq_post` follows that flag. Writing 1 to a status bit clears it. A set in the same cycle wins over the clear.
- R11: A software pointer write stores the written offset bits with the two low bits forced to zero. It overrides a hardware advance of the same pointer in the same cycle.
- R12: While the block is disabled, and for a push to queue 0 or 2 or a pop from queue 1 or 3, a request raises no strobe and changes no state, and `hw_rdata` is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Register write strobe |
| sw_addr | input | REG_AW | Register index |
| sw_wdata | input | ADDR_W | Register write data |
| sw_rdata | output | ADDR_W | Register read data (combinational) |
| hw_valid | input | 1 | Hardware queue request |
| hw_push | input | 1 | 1 = push, 0 = pop |
| hw_qsel | input | 2 | Queue index of the request |
| hw_wdata | input | DATA_W | Word to push |
| hw_rdata | output | DATA_W | Popped word, all ones when no pop is accepted |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| q_empty | output | 4 | Per-queue empty flags |
| irq_post | output | 1 | Post-queue interrupt |

## Verification
The bench builds the block with `UNIT_LG2` set to 4, so one size code gives a 16-byte queue holding four words, and a full queue and a wrap take only three or four requests. Size codes 0 to 3 are used. This covers the zero-span case, where every push overflows, and resizing on re-enable. Pointer writes outside their own region test the wrap-to-start rule. A behavioural model is compared every cycle against all outputs, and against register reads at a random index.

// File: rtl/qpm_pkg.sv
package qpm_pkg;
    localparam int NQ = 4;

    typedef enum logic [1:0] {
        Q_IFREE = 2'd0,
        Q_IPOST = 2'd1,
        Q_OPOST = 2'd2,
        Q_OFREE = 2'd3
    } qid_e;

    localparam int REG_CTRL = 0;
    localparam int REG_BASE = 1;
    localparam int REG_PTR0 = 2;
    localparam int REG_STAT = 10;
endpackage

// File: rtl/qpm_layout.sv
// Start offsets of the four queues for one size code.
module qpm_layout #(
    parameter int SIZE_W   = 5,
    parameter int UNIT_LG2 = 14,
    parameter int OFF_W    = 21
) (
    input  logic [SIZE_W-1:0]          size_code,
    output logic [3:0][OFF_W-1:0]      starts
);
    logic [OFF_W-1:0] span;

    assign span = OFF_W'(size_code) << UNIT_LG2;

    for (genvar q = 0; q < 4; q++) begin : g_start
        assign starts[q] = OFF_W'(span * OFF_W'(q));
    end
endmodule

// File: rtl/qpm_ptr_adv.sv
// One-word advance with wrap inside the queue's own region.
module qpm_ptr_adv #(
    parameter int OFF_W = 21
) (
    input  logic [OFF_W-1:0] ptr,
    input  logic [OFF_W-1:0] start,
    input  logic [OFF_W-1:0] span,
    output logic [OFF_W-1:0] nxt
);
    logic [OFF_W-1:0] rel;
    logic [OFF_W:0]   rel_step;
    logic             below;

    always_comb begin
        below    = ptr < start;
        rel      = ptr - start;
        rel_step = {1'b0, rel} + (OFF_W+1)'(4);
        if (below || rel_step >= {1'b0, span}) begin
            nxt = start;
        end else begin
            nxt = ptr + OFF_W'(4);
        end
    end
endmodule

// File: rtl/qpm_hw_decode.sv
// Turns one hardware request into per-queue advance strobes.
module qpm_hw_decode (
    input  logic       hw_valid,
    input  logic       hw_push,
    input  logic [1:0] hw_qsel,
    input  logic       en,
    input  logic [3:0] empty,
    input  logic [3:0] full,
    output logic [3:0] head_go,
    output logic [3:0] tail_go,
    output logic       ovf_evt,
    output logic       post_evt
);
    logic legal;
    logic live;

    // odd queues take pushes, even queues give pops
    assign legal = (hw_push == hw_qsel[0]);
    assign live  = hw_valid && en && legal;

    for (genvar q = 0; q < 4; q++) begin : g_q
        assign head_go[q] = live && hw_push  && (hw_qsel == 2'(q)) && !full[q];
        assign tail_go[q] = live && !hw_push && (hw_qsel == 2'(q)) && !empty[q];
    end

    assign ovf_evt  = live && hw_push && full[hw_qsel];
    assign post_evt = head_go[1];
endmodule

// File: rtl/qptr_mgr.sv
module qptr_mgr
    import qpm_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int SIZE_W   = 5,
    parameter int UNIT_LG2 = 14,
    parameter int BASE_LSB = 20,
    parameter int REG_AW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [REG_AW-1:0] sw_addr,
    input  logic [ADDR_W-1:0] sw_wdata,
    output logic [ADDR_W-1:0] sw_rdata,
    input  logic              hw_valid,
    input  logic              hw_push,
    input  logic [1:0]        hw_qsel,
    input  logic [DATA_W-1:0] hw_wdata,
    output logic [DATA_W-1:0] hw_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [3:0]        q_empty,
    output logic              irq_post
);
    localparam int OFF_W  = UNIT_LG2 + SIZE_W + 2;
    localparam int BASE_W = ADDR_W - BASE_LSB;

    typedef struct packed {
        logic                      en;
        logic [SIZE_W-1:0]         size;
        logic [BASE_W-1:0]         base;
        logic [NQ-1:0][OFF_W-1:0]  head;
        logic [NQ-1:0][OFF_W-1:0]  tail;
        logic                      post;
        logic                      ovf;
    } state_t;

    state_t st_d, st_q;

    logic [NQ-1:0][OFF_W-1:0] start_w;
    logic [NQ-1:0][OFF_W-1:0] start_new_w;
    logic [NQ-1:0][OFF_W-1:0] head_nx_w;
    logic [NQ-1:0][OFF_W-1:0] tail_nx_w;
    logic [OFF_W-1:0]         span_w;
    logic [3:0]               empty_w, full_w;
    logic [3:0]               head_go_w, tail_go_w;
    logic                     ovf_evt_w, post_evt_w;
    logic [ADDR_W-1:0]        region_w;

    qpm_layout #(.SIZE_W(SIZE_W), .UNIT_LG2(UNIT_LG2), .OFF_W(OFF_W)) u_lay (
        .size_code (st_q.size),
        .starts    (start_w)
    );

    qpm_layout #(.SIZE_W(SIZE_W), .UNIT_LG2(UNIT_LG2), .OFF_W(OFF_W)) u_lay_new (
        .size_code (sw_wdata[SIZE_W:1]),
        .starts    (start_new_w)
    );

    // queue 1 starts exactly one span above the base
    assign span_w = start_w[1];

    for (genvar q = 0; q < NQ; q++) begin : g_ptr
        qpm_ptr_adv #(.OFF_W(OFF_W)) u_head_adv (
            .ptr   (st_q.head[q]),
            .start (start_w[q]),
            .span  (span_w),
            .nxt   (head_nx_w[q])
        );
        qpm_ptr_adv #(.OFF_W(OFF_W)) u_tail_adv (
            .ptr   (st_q.tail[q]),
            .start (start_w[q]),
            .span  (span_w),
            .nxt   (tail_nx_w[q])
        );
        assign empty_w[q] = (st_q.head[q] == st_q.tail[q]);
        assign full_w[q]  = (head_nx_w[q] == st_q.tail[q]);
    end

    qpm_hw_decode u_dec (
        .hw_valid (hw_valid),
        .hw_push  (hw_push),
        .hw_qsel  (hw_qsel),
        .en       (st_q.en),
        .empty    (empty_w),
        .full     (full_w),
        .head_go  (head_go_w),
        .tail_go  (tail_go_w),
        .ovf_evt  (ovf_evt_w),
        .post_evt (post_evt_w)
    );

    // memory port
    assign region_w = {st_q.base, {BASE_LSB{1'b0}}};

    always_comb begin
        mem_we    = |head_go_w;
        mem_re    = |tail_go_w;
        mem_addr  = '0;
        mem_wdata = '0;
        hw_rdata  = '1;
        if (mem_we) begin
            mem_addr  = region_w + ADDR_W'(st_q.head[hw_qsel]);
            mem_wdata = hw_wdata;
        end else if (mem_re) begin
            mem_addr  = region_w + ADDR_W'(st_q.tail[hw_qsel]);
            hw_rdata  = mem_rdata;
        end
    end

    // register read
    always_comb begin
        sw_rdata = '0;
        if (sw_addr == REG_AW'(REG_CTRL)) sw_rdata = ADDR_W'({st_q.size, st_q.en});
        if (sw_addr == REG_AW'(REG_BASE)) sw_rdata = region_w;
        if (sw_addr == REG_AW'(REG_STAT)) sw_rdata = ADDR_W'({st_q.ovf, st_q.post});
        for (int q = 0; q < NQ; q++) begin
            if (sw_addr == REG_AW'(REG_PTR0 + 2*q))     sw_rdata = ADDR_W'(st_q.head[q]);
            if (sw_addr == REG_AW'(REG_PTR0 + 2*q + 1)) sw_rdata = ADDR_W'(st_q.tail[q]);
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        // status clear first so that a same-cycle event wins
        if (sw_we && sw_addr == REG_AW'(REG_STAT)) begin
            if (sw_wdata[0]) st_d.post = 1'b0;
            if (sw_wdata[1]) st_d.ovf  = 1'b0;
        end
        if (post_evt_w) st_d.post = 1'b1;
        if (ovf_evt_w)  st_d.ovf  = 1'b1;
        for (int q = 0; q < NQ; q++) begin
            if (head_go_w[q]) st_d.head[q] = head_nx_w[q];
            if (tail_go_w[q]) st_d.tail[q] = tail_nx_w[q];
        end
        // software writes override hardware advances
        if (sw_we) begin
            if (sw_addr == REG_AW'(REG_CTRL)) begin
                st_d.en   = sw_wdata[0];
                st_d.size = sw_wdata[SIZE_W:1];
                if (sw_wdata[0]) begin
                    for (int q = 0; q < NQ; q++) begin
                        st_d.head[q] = start_new_w[q];
                        st_d.tail[q] = start_new_w[q];
                    end
                end
            end
            if (sw_addr == REG_AW'(REG_BASE)) begin
                st_d.base = sw_wdata[ADDR_W-1:BASE_LSB];
            end
            for (int q = 0; q < NQ; q++) begin
                if (sw_addr == REG_AW'(REG_PTR0 + 2*q))
                    st_d.head[q] = {sw_wdata[OFF_W-1:2], 2'b00};
                if (sw_addr == REG_AW'(REG_PTR0 + 2*q + 1))
                    st_d.tail[q] = {sw_wdata[OFF_W-1:2], 2'b00};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_empty  = empty_w;
    assign irq_post = st_q.post;

    // assertions
    a_r3_enable_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && sw_addr == REG_AW'(REG_CTRL) && sw_wdata[0]) |=> (q_empty == 4'hF));

    a_r8_full_push_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_valid && hw_push && hw_qsel == 2'(Q_IPOST) && st_q.en && full_w[1] && !sw_we)
        |=> ($stable(st_q.head[1]) && st_q.ovf));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !(sw_we && sw_addr == REG_AW'(REG_STAT) && sw_wdata[1])) |=> st_q.ovf);

    a_r9_empty_pop_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_valid && !hw_push && !hw_qsel[0] && q_empty[hw_qsel]) |-> (hw_rdata == '1 && !mem_re));

    a_r10_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && hw_qsel == 2'(Q_IPOST)) |=> irq_post);

    a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |-> (!mem_we && !mem_re));
endmodule

// File: tb/sim_qptr_mgr.sv
module sim_qptr_mgr;
    localparam int PERIOD   = 10;
    localparam int UNIT_LG2 = 4;
    localparam int OFF_W    = UNIT_LG2 + 5 + 2;
    localparam logic [31:0] PTR_MASK = ((32'd1 << OFF_W) - 1) & ~32'd3;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        sw_we = 0;
    logic [3:0]  sw_addr = 0;
    logic [31:0] sw_wdata = 0;
    logic [31:0] sw_rdata;
    logic        hw_valid = 0, hw_push = 0;
    logic [1:0]  hw_qsel = 0;
    logic [31:0] hw_wdata = 0, hw_rdata;
    logic        mem_we, mem_re;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  q_empty;
    logic        irq_post;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    assign mem_rdata = ~mem_addr;

    always #(PERIOD/2) clk = ~clk;

    qptr_mgr #(.UNIT_LG2(UNIT_LG2)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .hw_valid(hw_valid), .hw_push(hw_push), .hw_qsel(hw_qsel),
        .hw_wdata(hw_wdata), .hw_rdata(hw_rdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .q_empty(q_empty), .irq_post(irq_post)
    );

    // behavioural model
    int m_en, m_size, m_post, m_ovf;
    logic [31:0] m_base;
    int m_head[4], m_tail[4];
    bit p_push_ok, p_pop_ok, p_ovf;

    function automatic int span();
        return m_size << UNIT_LG2;
    endfunction

    function automatic int qstart(int q);
        return q * span();
    endfunction

    function automatic int adv(int p, int q);
        int s = qstart(q);
        if (p < s || p - s + 4 >= span()) return s;
        return p + 4;
    endfunction

    function automatic logic [31:0] model_read(int a);
        if (a == 0) return 32'(m_size * 2 + m_en);
        if (a == 1) return m_base;
        if (a >= 2 && a <= 9) return ((a % 2) == 0) ? 32'(m_head[(a-2)/2]) : 32'(m_tail[(a-2)/2]);
        if (a == 10) return 32'(m_ovf * 2 + m_post);
        return 0;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic predict_and_compare();
        int q = int'(hw_qsel);
        bit go = hw_valid && m_en != 0 && (hw_push == hw_qsel[0]);
        bit full = adv(m_head[q], q) == m_tail[q];
        bit empty = m_head[q] == m_tail[q];
        logic [31:0] e_addr = 0, e_wd = 0, e_rd = 32'hFFFF_FFFF;
        logic [3:0] e_empty;
        p_push_ok = go && hw_push && !full;
        p_pop_ok  = go && !hw_push && !empty;
        p_ovf     = go && hw_push && full;
        if (p_push_ok) begin e_addr = m_base + 32'(m_head[q]); e_wd = hw_wdata; end
        if (p_pop_ok)  begin e_addr = m_base + 32'(m_tail[q]); e_rd = ~e_addr; end
        for (int i = 0; i < 4; i++) e_empty[i] = (m_head[i] == m_tail[i]);
        chk("R7 empty flags / R10 irq", {59'd0, e_empty == q_empty, irq_post}, {59'd0, 1'b1, 1'(m_post)});
        chk("R4/R5/R12 strobes and address", {mem_we, mem_re, 30'd0, mem_addr}, {p_push_ok, p_pop_ok, 30'd0, e_addr});
        chk("R4 write data", {32'd0, mem_wdata}, {32'd0, e_wd});
        chk("R5/R9 pop data", {32'd0, hw_rdata}, {32'd0, e_rd});
        chk("R2/R11 register read", {32'd0, sw_rdata}, {32'd0, model_read(int'(sw_addr))});
    endtask

    task automatic model_update();
        int q = int'(hw_qsel);
        int a = int'(sw_addr);
        if (sw_we && a == 10) begin
            if (sw_wdata[0]) m_post = 0;
            if (sw_wdata[1]) m_ovf = 0;
        end
        if (p_push_ok) begin m_head[q] = adv(m_head[q], q); if (q == 1) m_post = 1; end
        if (p_pop_ok) m_tail[q] = adv(m_tail[q], q);
        if (p_ovf) m_ovf = 1;
        if (sw_we) begin
            if (a == 0) begin
                m_en = int'(sw_wdata[0]);
                m_size = int'(sw_wdata[5:1]);
                if (m_en != 0) for (int i = 0; i < 4; i++) begin
                    m_head[i] = qstart(i);
                    m_tail[i] = qstart(i);
                end
            end
            if (a == 1) m_base = sw_wdata & 32'hFFF0_0000;
            if (a >= 2 && a <= 9) begin
                if ((a % 2) == 0) m_head[(a-2)/2] = int'(sw_wdata & PTR_MASK);
                else              m_tail[(a-2)/2] = int'(sw_wdata & PTR_MASK);
            end
        end
    endtask

    task automatic cyc();
        #2;
        predict_and_compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
        sw_we = 0;
        hw_valid = 0;
    endtask

    task automatic wr(int a, logic [31:0] d);
        sw_we = 1; sw_addr = 4'(a); sw_wdata = d;
        cyc();
    endtask

    task automatic hw(bit push, int q, logic [31:0] d);
        hw_valid = 1; hw_push = push; hw_qsel = 2'(q); hw_wdata = d;
    endtask

    task automatic rd(int a, logic [31:0] exp, string tag);
        sw_addr = 4'(a);
        #1;
        chk(tag, {32'd0, sw_rdata}, {32'd0, exp});
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        m_en = 0; m_size = 0; m_post = 0; m_ovf = 0; m_base = 0;
        for (int i = 0; i < 4; i++) begin m_head[i] = 0; m_tail[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 11; a++) rd(a, 0, "R1 reset register");
        chk("R1 reset empty", {60'd0, q_empty}, {60'd0, 4'hF});
        chk("R1 reset strobes", {62'd0, mem_we, mem_re}, 64'd0);
        // R12 disabled: push ignored
        hw(1, 1, 32'h11); #1;
        chk("R12 disabled push", {63'd0, mem_we}, 64'd0);
        cyc();
        rd(4, 0, "R12 disabled head unchanged");
        // R3 enable with size 1
        wr(0, 32'h3);
        rd(4, 16, "R3 ipost head start");
        rd(9, 48, "R3 ofree tail start");
        // R2 base masking
        wr(1, 32'h1234_5678);
        rd(1, 32'h1230_0000, "R2 base masked");
        // R4 pushes and R8 full
        hw(1, 1, 32'hA1); #1;
        chk("R4 push address", {32'd0, mem_addr}, {32'd0, 32'h1230_0010});
        cyc();
        hw(1, 1, 32'hA2); cyc();
        hw(1, 1, 32'hA3); cyc();
        hw(1, 1, 32'hA4); #1;
        chk("R8 full push dropped", {63'd0, mem_we}, 64'd0);
        cyc();
        rd(10, 3, "R8 R10 status flags");
        chk("R10 irq", {63'd0, irq_post}, 64'd1);
        // R6 wrap after software tail move
        wr(5, 32'd20);
        hw(1, 1, 32'hA5); #1;
        chk("R6 push at last word", {32'd0, mem_addr}, {32'd0, 32'h1230_001C});
        cyc();
        rd(4, 16, "R6 head wrapped");
        // R9 pop empty
        hw(0, 0, 0); #1;
        chk("R9 empty pop data", {32'd0, hw_rdata}, {32'd0, 32'hFFFF_FFFF});
        cyc();
        // R5 pop after CPU head move (R11 low bits dropped)
        wr(2, 32'd7);
        rd(2, 4, "R11 low bits cleared");
        hw(0, 0, 0); #1;
        chk("R5 pop data", {32'd0, hw_rdata}, {32'd0, 32'hEDCF_FFFF});
        cyc();
        rd(3, 4, "R5 tail advanced");
        // R12 illegal combination
        hw(1, 0, 32'h55); #1;
        chk("R12 push to pop-side queue", {63'd0, mem_we}, 64'd0);
        cyc();
        // R10 write-one-to-clear
        wr(10, 32'h1);
        rd(10, 2, "R10 post cleared");
        wr(10, 32'h2);
        rd(10, 0, "R8 overflow cleared");
        // R3 resize
        wr(0, 32'h5);
        rd(7, 64, "R3 opost tail at size 2");
        // R6 pointer outside its region
        wr(8, 32'h7FC);
        hw(1, 3, 32'h77); cyc();
        rd(10, 2, "R8 overflow from outside head");
        wr(9, 32'd200);
        hw(1, 3, 32'h78); #1;
        chk("R4 push outside head", {32'd0, mem_addr}, {32'd0, 32'h1230_07FC});
        cyc();
        rd(8, 96, "R6 outside head wraps to start");
        // size code zero
        wr(0, 32'h1);
        wr(10, 32'h3);
        hw(1, 1, 32'h9); cyc();
        rd(10, 2, "R8 zero span overflow");
        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            sw_addr = 4'($urandom_range(0, 15));
            if (r < 45) hw(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom);
            if (r >= 45 && r < 60) begin
                int k = $urandom_range(0, 9);
                sw_we = 1;
                if (k == 0) begin
                    sw_addr = 0;
                    sw_wdata = {26'd0, 5'($urandom_range(0, 3)), 1'($urandom_range(0, 7) != 0)};
                end else if (k == 1) begin
                    sw_addr = 10; sw_wdata = 32'($urandom_range(0, 3));
                end else if (k == 2) begin
                    sw_addr = 1; sw_wdata = $urandom;
                end else begin
                    sw_addr = 4'($urandom_range(2, 9)); sw_wdata = 32'($urandom_range(0, 300));
                end
            end
            cyc();
        end
        summary();
    end
endmodule